// File: doc/BRIEF.md
# Power Converter Mode Sequencer

This block decides the operating mode of a switching power controller and drives the enables that follow from that mode. It receives digitized comparator flags: the supply is above the start level, the supply is below the release level, the supply is below the switchover level, a wake level on the feedback input, a two-bit feedback-current band code, and a latched-fault flag. From these it selects one of six modes and drives a gate enable, a low-oscillator-rate select, a soft-start request, two discharge commands and a supply-source switchover request. The comparators, the regulation loop and the pulse-width generator sit outside this block.

The modes are OFF, STARTUP, NORMAL, STANDBY, POWER_DOWN and PROTECTION. The transitions are:
- OFF to STARTUP: a qualified wake while the supply is above start.
- STARTUP to NORMAL and STANDBY to NORMAL: the high band.
- NORMAL to STANDBY and POWER_DOWN to STANDBY: the mid band.
- NORMAL to POWER_DOWN and STANDBY to POWER_DOWN: the low band.
- Any active mode to PROTECTION: a fault.
- PROTECTION to OFF: the supply is below release.

STANDBY can only be reached after NORMAL, so POWER_DOWN can never be reached before NORMAL has been visited. The band code passes through a synchronizer and a stability filter. The wake level passes through a synchronizer and a duration qualifier.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode output is OFF and every other output is low.
- R2: OFF moves to STARTUP only when the wake input stays high for at least WAKE_QUAL_CYC consecutive cycles while vcc_above_start_i is high. The move happens WAKE_QUAL_CYC+2 cycles after the wake input rises. A shorter wake, or a wake while the supply is not above start, leaves the block in OFF.
- R3: In STARTUP, gate_en_o, low_freq_o and softstart_o are high, and both discharge outputs are low.
- R4: The band code (00 low, 01 mid, 10 high) must stay unchanged on the input for at least BAND_STABLE_CYC+1 cycles before it takes effect. The mode then changes BAND_STABLE_CYC+4 cycles after the code was applied. A code held for BAND_STABLE_CYC cycles or fewer has no effect.
- R5: The high band moves STARTUP or STANDBY to NORMAL. In NORMAL, gate_en_o is high and low_freq_o and softstart_o are low.
- R6: The mid band moves NORMAL or POWER_DOWN to STANDBY. In STANDBY, gate_en_o and low_freq_o are high. The mid band has no effect in STARTUP.
- R7: The low band moves NORMAL or STANDBY to POWER_DOWN, where gate_en_o is low. The low band has no effect in STARTUP, and the high band has no effect in POWER_DOWN.
- R8: fault_i moves any active mode to PROTECTION on the next cycle. PROTECTION drives gate_en_o low and dis_vcc_o and dis_sst_o high. fault_i has no effect in OFF.
- R9: PROTECTION holds regardless of band. It is left only to OFF, one cycle after vcc_below_release_i is high.
- R10: supply_switch_o goes high one cycle after vcc_switch_low_i goes high while in STANDBY, and follows that flag one cycle later. In every other mode it stays low.
- R11: mode_o is one-hot with bit 0 OFF, bit 1 STARTUP, bit 2 NORMAL, bit 3 STANDBY, bit 4 POWER_DOWN, bit 5 PROTECTION. All outputs are registered and change on the same edge as mode_o.
- R12: The reserved band code 11 causes no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_start_i | input | 1 | Supply is above the start level |
| vcc_below_release_i | input | 1 | Supply is below the protection release level |
| vcc_switch_low_i | input | 1 | Supply is below the switchover level |
| wake_i | input | 1 | Wake level on the feedback input |
| fb_band_i | input | 2 | Feedback current band code |
| fault_i | input | 1 | Latched fault flag |
| mode_o | output | 6 | One-hot mode |
| gate_en_o | output | 1 | Gate drive enable |
| low_freq_o | output | 1 | Low oscillator rate select |
| softstart_o | output | 1 | Soft-start request |
| dis_vcc_o | output | 1 | Supply discharge command |
| dis_sst_o | output | 1 | Soft-start capacitor discharge command |
| supply_switch_o | output | 1 | Supply source switchover request |

## Verification
Each result has a fixed latency:
- A band change reaches mode_o BAND_STABLE_CYC+4 cycles after it is applied: two synchronizer stages, the filter's candidate load, BAND_STABLE_CYC-1 count cycles, the filtered band register and the mode register.
- A qualified wake lands WAKE_QUAL_CYC+2 cycles after the wake input rises.
- A fault, a release or a switchover flag is due one cycle later.

Each stimulus queues the expected output word with the absolute cycle in which it is due. For band and wake stimuli, the cycle before the due cycle is also queued with the old mode, so a result that arrives one cycle early or late is caught. The monitor compares at the falling edge of the due cycle. A reserved or ignored stimulus is checked well past the longest latency.

// File: rtl/pms_pkg.sv
package pms_pkg;

    localparam int NUM_MODES = 6;

    typedef enum logic [2:0] {
        M_OFF   = 3'd0,
        M_START = 3'd1,
        M_RUN   = 3'd2,
        M_IDLE  = 3'd3,
        M_PDN   = 3'd4,
        M_PROT  = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        B_LOW  = 2'b00,
        B_MID  = 2'b01,
        B_HIGH = 2'b10,
        B_RSVD = 2'b11
    } band_e;

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= '0;
                end else if (i == 0) begin
                    stage_q[i] <= d;
                end else begin
                    stage_q[i] <= stage_q[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pms_band_filter.sv
module pms_band_filter
    import pms_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  band_raw,
    output band_e       band_q
);
    localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) + 1 : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(STABLE_CYC - 1);

    logic [1:0]    sync_q;
    logic [1:0]    cand_q;
    logic [CW-1:0] cnt_q;

    pms_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (band_raw),
        .q     (sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= B_LOW;
            cnt_q  <= '0;
            band_q <= B_LOW;
        end else if (cand_q != sync_q) begin
            cand_q <= sync_q;
            cnt_q  <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            band_q <= band_e'(cand_q);
        end
    end

    AST_BAND_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (band_q != $past(band_q)) |-> ($past(sync_q) == band_q)) // R4
        else $error("filtered band changed without a matching synchronized sample");
endmodule

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_raw,
    output logic wake_ok
);
    localparam int CW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) + 1 : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_CYC - 1);

    logic          sync_q;
    logic [CW-1:0] run_q;

    pms_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_raw),
        .q     (sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sync_q) begin
            run_q <= '0;
        end else if (run_q != CNT_TOP) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign wake_ok = sync_q && (run_q == CNT_TOP);

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ok && (QUAL_CYC > 1)) |-> $past(sync_q)) // R2
        else $error("wake accepted without a preceding high sample");
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
    import pms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vcc_above_start,
    input  logic                 vcc_below_release,
    input  logic                 vcc_switch_low,
    input  logic                 wake_ok,
    input  band_e                band,
    input  logic                 fault,
    output logic [NUM_MODES-1:0] mode_oh,
    output logic                 gate_en,
    output logic                 low_freq,
    output logic                 softstart,
    output logic                 dis_vcc,
    output logic                 dis_sst,
    output logic                 supply_switch
);
    mode_e state_q, state_d;
    logic  active;

    assign active = (state_q == M_START) || (state_q == M_RUN) ||
                    (state_q == M_IDLE)  || (state_q == M_PDN);

    always_comb begin
        state_d = state_q;
        if (active && fault) begin
            state_d = M_PROT;
        end else begin
            unique case (state_q)
                M_OFF:   if (vcc_above_start && wake_ok) state_d = M_START;
                M_START: if (band == B_HIGH) state_d = M_RUN;
                M_RUN: begin
                    if (band == B_MID)      state_d = M_IDLE;
                    else if (band == B_LOW) state_d = M_PDN;
                end
                M_IDLE: begin
                    if (band == B_HIGH)     state_d = M_RUN;
                    else if (band == B_LOW) state_d = M_PDN;
                end
                M_PDN:   if (band == B_MID) state_d = M_IDLE;
                M_PROT:  if (vcc_below_release) state_d = M_OFF;
                default: state_d = M_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_oh       <= NUM_MODES'(1);
            gate_en       <= 1'b0;
            low_freq      <= 1'b0;
            softstart     <= 1'b0;
            dis_vcc       <= 1'b0;
            dis_sst       <= 1'b0;
            supply_switch <= 1'b0;
        end else begin
            mode_oh       <= NUM_MODES'(1) << state_d;
            gate_en       <= 1'b0;
            low_freq      <= 1'b0;
            softstart     <= 1'b0;
            dis_vcc       <= 1'b0;
            dis_sst       <= 1'b0;
            supply_switch <= 1'b0;
            unique case (state_d)
                M_OFF: ;
                M_START: begin
                    gate_en   <= 1'b1;
                    low_freq  <= 1'b1;
                    softstart <= 1'b1;
                end
                M_RUN:   gate_en <= 1'b1;
                M_IDLE: begin
                    gate_en       <= 1'b1;
                    low_freq      <= 1'b1;
                    supply_switch <= vcc_switch_low;
                end
                M_PDN: ;
                M_PROT: begin
                    dis_vcc <= 1'b1;
                    dis_sst <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_oh) == 1) // R11
        else $error("mode vector not one-hot");

    AST_OFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_OFF) |=> (state_q == M_OFF || state_q == M_START)) // R2
        else $error("OFF left to a mode other than STARTUP");

    AST_FAULT_TO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && active) |=> (state_q == M_PROT)) // R8
        else $error("fault did not reach protection");

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[M_OFF] || mode_oh[M_PDN] || mode_oh[M_PROT]) |-> !gate_en) // R8
        else $error("gate enabled in an idle mode");

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_PROT && !vcc_below_release) |=> (state_q == M_PROT)) // R9
        else $error("protection left without release");

    AST_PROT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_PROT) |=> (state_q == M_PROT || state_q == M_OFF)) // R9
        else $error("protection left to a mode other than OFF");

    AST_PDN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_PDN && $past(state_q) != M_PDN) |->
        ($past(state_q) == M_RUN || $past(state_q) == M_IDLE)) // R7
        else $error("power-down entered from a mode before NORMAL");
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int BAND_STABLE_CYC = 4,
    parameter int WAKE_QUAL_CYC   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_above_start_i,
    input  logic       vcc_below_release_i,
    input  logic       vcc_switch_low_i,
    input  logic       wake_i,
    input  logic [1:0] fb_band_i,
    input  logic       fault_i,
    output logic [5:0] mode_o,
    output logic       gate_en_o,
    output logic       low_freq_o,
    output logic       softstart_o,
    output logic       dis_vcc_o,
    output logic       dis_sst_o,
    output logic       supply_switch_o
);
    band_e band_f;
    logic  wake_ok;

    pms_band_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .STABLE_CYC  (BAND_STABLE_CYC)
    ) u_band (
        .clk      (clk),
        .rst_n    (rst_n),
        .band_raw (fb_band_i),
        .band_q   (band_f)
    );

    pms_wake_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYC    (WAKE_QUAL_CYC)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_raw (wake_i),
        .wake_ok  (wake_ok)
    );

    pms_mode_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .vcc_above_start   (vcc_above_start_i),
        .vcc_below_release (vcc_below_release_i),
        .vcc_switch_low    (vcc_switch_low_i),
        .wake_ok           (wake_ok),
        .band              (band_f),
        .fault             (fault_i),
        .mode_oh           (mode_o),
        .gate_en           (gate_en_o),
        .low_freq          (low_freq_o),
        .softstart         (softstart_o),
        .dis_vcc           (dis_vcc_o),
        .dis_sst           (dis_sst_o),
        .supply_switch     (supply_switch_o)
    );

    AST_SWITCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        supply_switch_o |-> mode_o[M_IDLE]) // R10
        else $error("switchover requested outside STANDBY");
endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL   = 8;
    localparam int STABLE = 4;
    localparam int BAND_LAT = STABLE + 4;
    localparam int WAKE_LAT = QUAL + 2;
    localparam int OFF = 0, START = 1, RUN = 2, IDLE = 3, PDN = 4, PROT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_above_start_i = 1'b0;
    logic       vcc_below_release_i = 1'b0;
    logic       vcc_switch_low_i = 1'b0;
    logic       wake_i = 1'b0;
    logic [1:0] fb_band_i = 2'b00;
    logic       fault_i = 1'b0;
    logic [5:0] mode_o;
    logic       gate_en_o, low_freq_o, softstart_o, dis_vcc_o, dis_sst_o, supply_switch_o;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    typedef struct {
        int          due;
        logic [11:0] val;
        string       req;
    } item_t;
    item_t sb_q[$];

    pwr_mode_seq #(
        .SYNC_STAGES     (2),
        .BAND_STABLE_CYC (STABLE),
        .WAKE_QUAL_CYC   (QUAL)
    ) uut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .vcc_above_start_i   (vcc_above_start_i),
        .vcc_below_release_i (vcc_below_release_i),
        .vcc_switch_low_i    (vcc_switch_low_i),
        .wake_i              (wake_i),
        .fb_band_i           (fb_band_i),
        .fault_i             (fault_i),
        .mode_o              (mode_o),
        .gate_en_o           (gate_en_o),
        .low_freq_o          (low_freq_o),
        .softstart_o         (softstart_o),
        .dis_vcc_o           (dis_vcc_o),
        .dis_sst_o           (dis_sst_o),
        .supply_switch_o     (supply_switch_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] exp_out(int m, bit sw);
        logic [5:0] oh;
        logic g, lf, ss, dis;
        oh  = 6'b1 << m;
        g   = (m == START) || (m == RUN) || (m == IDLE);
        lf  = (m == START) || (m == IDLE);
        ss  = (m == START);
        dis = (m == PROT);
        return {oh, g, lf, ss, dis, dis, sw};
    endfunction

    task automatic expect_at(int d, int m, bit sw, string req);
        item_t it;
        it.due = cyc + d;
        it.val = exp_out(m, sw);
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        item_t it;
        logic [11:0] obs;
        obs = {mode_o, gate_en_o, low_freq_o, softstart_o, dis_vcc_o, dis_sst_o, supply_switch_o};
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            it = sb_q.pop_front();
            checks++;
            if (obs !== it.val) begin
                fails++;
                $display("FAIL %s at cycle %0d: got %b expected %b", it.req, cyc, obs, it.val);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        expect_at(1, OFF, 0, "R1");
        wait_n(2);

        // R8: fault while OFF is ignored
        fault_i = 1'b1;
        expect_at(2, OFF, 0, "R8");
        wait_n(3);
        fault_i = 1'b0;

        // R2: wake one cycle short of qualification
        vcc_above_start_i = 1'b1;
        wake_i = 1'b1;
        expect_at(14, OFF, 0, "R2");
        wait_n(QUAL - 1);
        wake_i = 1'b0;
        wait_n(16);

        // R2: long wake without supply above start
        vcc_above_start_i = 1'b0;
        wake_i = 1'b1;
        expect_at(14, OFF, 0, "R2");
        wait_n(16);
        wake_i = 1'b0;
        wait_n(5);

        // R2 R3: wake held exactly the qualifying length
        vcc_above_start_i = 1'b1;
        wake_i = 1'b1;
        expect_at(WAKE_LAT - 1, OFF, 0, "R2");
        expect_at(WAKE_LAT, START, 0, "R3");
        wait_n(QUAL);
        wake_i = 1'b0;
        wait_n(6);

        // R7: low band in STARTUP has no effect
        expect_at(3, START, 0, "R7");
        wait_n(4);

        // R6: mid band in STARTUP has no effect
        fb_band_i = 2'b01;
        expect_at(14, START, 0, "R6");
        wait_n(16);

        // R12: reserved code
        fb_band_i = 2'b11;
        expect_at(14, START, 0, "R12");
        wait_n(16);

        // R4: high band held only STABLE cycles
        fb_band_i = 2'b10;
        expect_at(14, START, 0, "R4");
        wait_n(STABLE);
        fb_band_i = 2'b01;
        wait_n(14);

        // R4 R5: high band held
        fb_band_i = 2'b10;
        expect_at(BAND_LAT - 1, START, 0, "R4");
        expect_at(BAND_LAT, RUN, 0, "R5");
        wait_n(12);

        // R6: mid band from NORMAL
        fb_band_i = 2'b01;
        expect_at(BAND_LAT - 1, RUN, 0, "R4");
        expect_at(BAND_LAT, IDLE, 0, "R6");
        wait_n(12);

        // R10: switchover in STANDBY
        vcc_switch_low_i = 1'b1;
        expect_at(1, IDLE, 1, "R10");
        wait_n(3);
        vcc_switch_low_i = 1'b0;
        expect_at(1, IDLE, 0, "R10");
        wait_n(3);

        // R5: high band from STANDBY
        fb_band_i = 2'b10;
        expect_at(BAND_LAT, RUN, 0, "R5");
        wait_n(12);

        // R10: switchover flag outside STANDBY
        vcc_switch_low_i = 1'b1;
        expect_at(2, RUN, 0, "R10");
        wait_n(3);
        vcc_switch_low_i = 1'b0;

        // R7: low band from NORMAL
        fb_band_i = 2'b00;
        expect_at(BAND_LAT, PDN, 0, "R7");
        wait_n(12);

        // R7: high band in POWER_DOWN has no effect
        fb_band_i = 2'b10;
        expect_at(14, PDN, 0, "R7");
        wait_n(16);

        // R6: mid band from POWER_DOWN
        fb_band_i = 2'b01;
        expect_at(BAND_LAT, IDLE, 0, "R6");
        wait_n(12);

        // R7: low band from STANDBY
        fb_band_i = 2'b00;
        expect_at(BAND_LAT, PDN, 0, "R7");
        wait_n(12);

        // R8: fault from POWER_DOWN
        fault_i = 1'b1;
        expect_at(1, PROT, 0, "R8");
        wait_n(3);

        // R9: protection holds against band changes and without release
        fb_band_i = 2'b10;
        expect_at(14, PROT, 0, "R9");
        wait_n(16);

        // R9: release to OFF
        vcc_below_release_i = 1'b1;
        expect_at(1, OFF, 0, "R9");
        wait_n(3);
        fault_i = 1'b0;
        vcc_below_release_i = 1'b0;
        fb_band_i = 2'b00;
        wait_n(12);

        // R8: fault from STARTUP
        wake_i = 1'b1;
        expect_at(WAKE_LAT, START, 0, "R3");
        wait_n(WAKE_LAT + 2);
        wake_i = 1'b0;
        fault_i = 1'b1;
        expect_at(1, PROT, 0, "R8");
        wait_n(4);
        fault_i = 1'b0;

        wait_n(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule